// File: doc/BRIEF.md
# Parallel Multi-Lane Sine Synthesizer

This block produces a sampled sine tone whose sample rate is a multiple of the fabric clock. On every clock it computes LANES consecutive samples of one tone side by side. The samples leave as one wide word, and an external serializer can send that word to a fast converter one sample after another. One shared phase accumulator moves forward by LANES tuning steps per clock. Each lane adds its own multiple of the tuning word to that base, so the lanes hold successive points of the same waveform and not separate tones.

A plain table lookup is accurate to about 8 bits. Each lane therefore reads two neighbouring entries of a full-wave table and interpolates linearly between them, using the phase bits just below the table index. The result is rounded and clipped to the output width. A two-stage pipeline gives a fixed latency, and a valid flag follows the enable input through the same delay.

Top module: `sine_par_synth`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the pipeline and the valid flag, and drives every output sample to 0. The first valid word after reset starts at phase 0, so lane 0 of that word is 0.
- R2: Let n be the number of enabled clocks since reset, counted from 0. Lane k (0..LANES-1) of word n takes the phase (n*LANES + k)*ftw mod 2^32. Lane k sits in bits [k*OUT_W +: OUT_W] of the sample bus, so lane 0 is the earliest sample and occupies the lowest bits.
- R3: Phase bits [31:24] give the table index i and bits [23:16] give the fraction f. Table entry i is round(32767*sin(2*pi*i/256)), and the following entry is (i+1) mod 256.
- R4: The interpolated value is t[i] + floor((t[(i+1) mod 256] - t[i]) * f / 256), so it always lies between the two table entries.
- R5: The output sample is floor((v + 2) / 4) of the interpolated value v, clipped to the signed 14-bit range [-8192, 8191].
- R6: valid equals en delayed by exactly two clocks. Samples computed from inputs taken at clock edge E appear after edge E+1.
- R7: While en is low the accumulator holds its value. The next enabled word therefore carries on the sequence with no phase jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the phase and produce a word this clock |
| ftw | input | PHASE_W | Frequency tuning word: phase step per output sample |
| samples | output | LANES*OUT_W | Packed signed samples, lane 0 in the lowest bits |
| valid | output | 1 | The sample word is a real output word |

## Verification
The latency assertions assume that en is held low during reset, so the valid pipeline starts empty. They also assume en is a clean 0 or 1 at every sampling edge. The interpolation and rounding assertions need only that the table entries are set when elaboration ends; the fraction cannot leave its range because of its width. The stimulus drives en and ftw only on falling edges, keeps en low through every reset, and changes ftw only while reset is applied. As a result each tone runs from phase zero at one constant step.

// File: rtl/sine_par_pkg.sv
package sine_par_pkg;

  // Rounded full-wave sine entry; used only to build the constant table.
  function automatic int sine_entry(int i, int depth, int amp);
    real a;
    a = real'(amp) * $sin(6.283185307179586 * real'(i) / real'(depth));
    if (a >= 0.0) return $rtoi(a + 0.5);
    else return $rtoi(a - 0.5);
  endfunction

  // Linear interpolation between lo and hi by frac / 2^frac_w (floor).
  function automatic int interp_fn(int lo, int hi, int frac, int frac_w);
    int span;
    span = (hi - lo) * frac;
    return lo + (span >>> frac_w);
  endfunction

  // Drop sh bits with round-half-up, then clip to a signed ow-bit range.
  function automatic int round_sat_fn(int v, int sh, int ow);
    int r;
    int top;
    int bot;
    top = (1 << (ow - 1)) - 1;
    bot = -(1 << (ow - 1));
    r = (v + (1 << (sh - 1))) >>> sh;
    if (r > top) r = top;
    else if (r < bot) r = bot;
    return r;
  endfunction

endpackage

// File: rtl/sine_phase_gen.sv
module sine_phase_gen #(
  parameter int LANES   = 4,
  parameter int PHASE_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en,
  input  logic [PHASE_W-1:0]                ftw,
  output logic [LANES-1:0][PHASE_W-1:0]     lane_phase
);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] word_step;

  assign word_step = ftw * PHASE_W'(LANES);

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_q + word_step;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_phase[k] = acc_q + ftw * PHASE_W'(k);
  end

  // R7: accumulator frozen while disabled
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));

endmodule

// File: rtl/sine_lane.sv
module sine_lane #(
  parameter int ADDR_W = 8,
  parameter int FRAC_W = 8,
  parameter int TBL_W  = 16,
  parameter int OUT_W  = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W+FRAC_W-1:0]   phase,
  output logic signed [OUT_W-1:0]    sample
);
  import sine_par_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMP   = (1 << (TBL_W - 1)) - 1;
  localparam int SH    = TBL_W - OUT_W;
  localparam int HALF  = 1 << (SH - 1);
  localparam int SCALE = 1 << SH;
  localparam int OMAX  = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN  = -(1 << (OUT_W - 1));

  logic signed [TBL_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = TBL_W'(sine_entry(g, DEPTH, AMP));
  end

  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] idx_nx;
  logic [FRAC_W-1:0] frac;

  assign idx    = phase[ADDR_W+FRAC_W-1 -: ADDR_W];
  assign idx_nx = idx + ADDR_W'(1);
  assign frac   = phase[FRAC_W-1:0];

  // Stage 1: table reads and fraction
  logic signed [TBL_W-1:0] lo_q;
  logic signed [TBL_W-1:0] hi_q;
  logic [FRAC_W-1:0]       frac_q;

  // Named internal results for the assertions
  int interp_int;
  int rounded_int;

  assign interp_int  = interp_fn(int'(lo_q), int'(hi_q), int'(frac_q), FRAC_W);
  assign rounded_int = round_sat_fn(interp_int, SH, OUT_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      frac_q <= '0;
      sample <= '0;
    end else begin
      lo_q   <= rom[idx];
      hi_q   <= rom[idx_nx];
      frac_q <= frac;
      sample <= OUT_W'(rounded_int);
    end
  end

  // R4: interpolated value lies between its two table entries
  p_interp_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(lo_q) <= int'(hi_q)) ?
      (interp_int >= int'(lo_q) && interp_int <= int'(hi_q)) :
      (interp_int <= int'(lo_q) && interp_int >= int'(hi_q)));

  // R5: output is within half a step of the interpolated value, or clipped
  p_round_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((int'(sample) * SCALE - $past(interp_int) <= HALF) &&
              (int'(sample) * SCALE - $past(interp_int) >= -HALF)) ||
             int'(sample) == OMAX || int'(sample) == OMIN);

endmodule

// File: rtl/sine_par_synth.sv
module sine_par_synth #(
  parameter int LANES   = 4,
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8,
  parameter int FRAC_W  = 8,
  parameter int TBL_W   = 16,
  parameter int OUT_W   = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [PHASE_W-1:0]       ftw,
  output logic [LANES*OUT_W-1:0]   samples,
  output logic                     valid
);

  localparam int LAT    = 2;
  localparam int PH_TOP = ADDR_W + FRAC_W;

  logic [LANES-1:0][PHASE_W-1:0] lane_phase;
  logic signed [OUT_W-1:0]       lane_sample [LANES];

  sine_phase_gen #(.LANES(LANES), .PHASE_W(PHASE_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .ftw        (ftw),
    .lane_phase (lane_phase)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sine_lane #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .TBL_W(TBL_W), .OUT_W(OUT_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .phase  (lane_phase[k][PHASE_W-1 -: PH_TOP]),
      .sample (lane_sample[k])
    );
    assign samples[k*OUT_W +: OUT_W] = lane_sample[k];
  end

  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], en};
  end

  assign valid = vpipe[LAT-1];

  // R6: valid follows en two clocks later
  p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
    en |=> ##1 valid);
  p_valid_fall_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> ##1 !valid);

endmodule

// File: tb/sim_sine_par_synth.sv
module sim_sine_par_synth;
  localparam int LANES = 4;
  localparam int OUT_W = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [31:0] ftw = '0;
  logic [LANES*OUT_W-1:0] samples;
  logic valid;

  int n_chk = 0;
  int n_fail = 0;
  int word_idx = 0;
  logic [31:0] cur_ftw = '0;
  string tag = "R2";
  bit en_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sine_par_synth u0 (
    .clk(clk), .rst(rst), .en(en), .ftw(ftw), .samples(samples), .valid(valid)
  );

  function automatic int ref_tbl(int i);
    real a;
    a = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 256.0);
    return int'($floor(a + 0.5));
  endfunction

  function automatic int floor_div(int num, int den);
    if (num >= 0) return num / den;
    return -((-num + den - 1) / den);
  endfunction

  function automatic int ref_sample(logic [31:0] ph);
    int i, f, a, b, v, o;
    i = int'(ph[31:24]);
    f = int'(ph[23:16]);
    a = ref_tbl(i);
    b = ref_tbl((i + 1) % 256);
    v = a + floor_div((b - a) * f, 256);
    o = floor_div(v + 2, 4);
    if (o > 8191) o = 8191;
    if (o < -8192) o = -8192;
    return o;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: sample away from the edge
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      chk(valid == en_prev, "R6 valid", int'(valid), int'(en_prev));
      if (valid) begin
        for (int k = 0; k < LANES; k++) begin
          logic [31:0] ph;
          int act, expv;
          ph = 32'(word_idx * LANES + k) * cur_ftw;
          expv = ref_sample(ph);
          act = int'($signed(samples[k*OUT_W +: OUT_W]));
          if (word_idx == 0 && k == 0) chk(act == expv && act == 0, "R1 first sample", act, 0);
          else chk(act == expv, tag, act, expv);
        end
        word_idx++;
      end
    end
    en_prev = en;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en = 1'b0;
    repeat (3) @(negedge clk);
    word_idx = 0;
    rst = 1'b0;
  endtask

  task automatic run_tone(logic [31:0] f, int nwords, string t, bit gaps);
    @(negedge clk);
    rst = 1'b1;
    en = 1'b0;
    ftw = f;
    cur_ftw = f;
    tag = t;
    repeat (3) @(negedge clk);
    word_idx = 0;
    rst = 1'b0;
    for (int i = 0; i < nwords; i++) begin
      en = (gaps && (i % 3 == 2)) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
    chk(samples == '0, "R1 samples after reset", int'(samples != '0), 0);
    run_tone(32'h0100_0000, 70, "R3 table points", 1'b0);
    run_tone(32'h0012_3457, 40, "R4 interpolation", 1'b0);
    for (int i = 0; i < 12; i++)
      run_tone(32'h0101_0000 + 32'(i) * 32'h0A3D_70A5, 64, "R4 sweep", 1'b0);
    run_tone(32'h4000_0000, 8, "R5 clip", 1'b0);
    run_tone(32'h3FFF_0000, 8, "R5 near peak", 1'b0);
    run_tone(32'h0F0F_0F0F, 30, "R2 lane order", 1'b0);
    run_tone(32'h0123_4567, 30, "R7 hold on gaps", 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule